// File: doc/BRIEF.md
# Masked Interrupt Status Register Group

This block is a small memory-mapped register group that turns hardware event pulses into one level interrupt. Each event input sets a sticky status bit. Each status bit has a mask bit. The interrupt output is high while any status bit is set and its mask bit is clear. Software clears a status bit by writing a one to it.

The mask cannot be written directly. Software changes it through two write-only alias locations. One alias unmasks the bits written as one. The other alias masks the bits written as one. Neither alias stores a value of its own.

The bus is a simple single-cycle register port with address, write data, write strobe, read strobe and read data. Every access is one full, aligned, little-endian data word. Read data is combinational, so it is valid in the same cycle as the read strobe. The number of sources, the data width, the reset mask and the four word offsets are parameters. A generate option adds a register stage on the interrupt output.

Top module: `isr_group`

## Requirements
- R1: After reset, all status bits are 0 and every mask bit holds its reset value. The default reset mask is 0x1, so the single default source starts masked. The interrupt output is 0.
- R2: A write to the status offset (default 0x00) clears each status bit written as 1, from the next clock edge. Status bits written as 0 are unchanged.
- R3: A high event input sets its status bit at the next clock edge. If an event arrives in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R4: The interrupt output is the OR over all sources of (status AND NOT mask). In the default variant it follows the stored bits with no extra cycle, so it reflects a write in the cycle after that write.
- R5: A write to the mask offset (default 0x04) changes no mask bit.
- R6: A write to the enable alias (default 0x08) clears each mask bit written as 1. Mask bits written as 0 are unchanged.
- R7: A write to the disable alias (default 0x0C) sets each mask bit written as 1. Mask bits written as 0 are unchanged.
- R8: A read of the enable alias or the disable alias returns 0.
- R9: Only aligned accesses take effect. An access is aligned when the address bits below the word size (bits [1:0] for 32-bit data) are 0. A misaligned write changes nothing, and a misaligned read returns 0.
- R10: A read returns its data combinationally, in the same cycle as the read strobe:
  - a status or mask read returns the current stored bits, with the bits above the source count as 0;
  - a read of an unmapped offset returns 0;
  - with the read strobe low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Combinational read data |
| hw_event | input | NUM_SRC | Per-source set pulses |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a fixed-seed random mix of these operations against a reference model:
- status writes;
- direct mask writes;
- enable-alias and disable-alias writes;
- misaligned writes;
- reads, with random event pulses that often coincide with clears.

Directed cases isolate the situations that the random mix can blur:
- an event landing on a clear, which separates event priority from clear priority;
- a zero-data status write, which separates "write one to clear" from "any write clears";
- a direct mask write, which shows that the mask has no write path;
- misaligned and unmapped reads, which show whether decoding uses the low address bits.

After every operation, the interrupt output is compared with the model. This shows whether the mask is applied with the right polarity and in the right cycle.

// File: rtl/isr_pkg.sv
package isr_pkg;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_STAT = 3'd1,
      SEL_MASK = 3'd2,
      SEL_ENA  = 3'd3,
      SEL_DIS  = 3'd4
   } isr_sel_e;

endpackage

// File: rtl/isr_addr_dec.sv
module isr_addr_dec
   import isr_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          LANE_W   = 2,
   parameter logic [31:0] OFF_STAT = 32'h00,
   parameter logic [31:0] OFF_MASK = 32'h04,
   parameter logic [31:0] OFF_ENA  = 32'h08,
   parameter logic [31:0] OFF_DIS  = 32'h0C
)(
   input  logic [ADDR_W-1:0] addr,
   output isr_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_STAT = OFF_STAT[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_MASK = OFF_MASK[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_ENA  = OFF_ENA[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_DIS  = OFF_DIS[ADDR_W-1:0];

   logic aligned;

   generate
      if (LANE_W > 0) begin : g_lane
         assign aligned = (addr[LANE_W-1:0] == '0);
      end else begin : g_nolane
         assign aligned = 1'b1;
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (aligned) begin
         if      (addr == A_STAT) sel = SEL_STAT;
         else if (addr == A_MASK) sel = SEL_MASK;
         else if (addr == A_ENA)  sel = SEL_ENA;
         else if (addr == A_DIS)  sel = SEL_DIS;
      end
   end
endmodule

// File: rtl/isr_stat_bank.sv
module isr_stat_bank #(
   parameter int NUM_SRC = 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] clr,
   input  logic [NUM_SRC-1:0] set,
   output logic [NUM_SRC-1:0] stat
);
   genvar i;
   generate
      for (i = 0; i < NUM_SRC; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stat[i] <= 1'b0;
            else if (set[i]) stat[i] <= 1'b1;
            else if (clr[i]) stat[i] <= 1'b0;
         end

         // R3: an event wins over a same-cycle clear
         assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> stat[i]);

         // R2: a clear without an event empties the bit
         assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !stat[i]);

         assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !set[i]) |=> $stable(stat[i]));
      end
   endgenerate
endmodule

// File: rtl/isr_mask_bank.sv
module isr_mask_bank #(
   parameter int               NUM_SRC  = 1,
   parameter logic [NUM_SRC-1:0] MASK_RST = '1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] unmask,
   input  logic [NUM_SRC-1:0] domask,
   output logic [NUM_SRC-1:0] mask
);
   genvar i;
   generate
      for (i = 0; i < NUM_SRC; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         mask[i] <= MASK_RST[i];
            else if (domask[i]) mask[i] <= 1'b1;
            else if (unmask[i]) mask[i] <= 1'b0;
         end

         // R6: the enable alias clears the mask bit
         assert_unmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (unmask[i] && !domask[i]) |=> !mask[i]);

         // R7: the disable alias sets the mask bit
         assert_domask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            domask[i] |=> mask[i]);

         // R5: no other path changes the mask
         assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!unmask[i] && !domask[i]) |=> $stable(mask[i]));
      end
   endgenerate
endmodule

// File: rtl/isr_irq_out.sv
module isr_irq_out #(
   parameter int NUM_SRC = 1,
   parameter bit IRQ_REG = 1'b0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] stat,
   input  logic [NUM_SRC-1:0] mask,
   output logic               irq
);
   logic pend;

   assign pend = |(stat & ~mask);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend;
         end

         assign irq = irq_q;

         // R4: the registered output follows the pending term one cycle later
         assert_irq_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pend |=> irq);
      end else begin : g_comb
         assign irq = pend;
      end
   endgenerate
endmodule

// File: rtl/isr_group.sv
module isr_group
   import isr_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 32,
   parameter int          NUM_SRC  = 1,
   parameter logic [31:0] MASK_RST = 32'h1,
   parameter logic [31:0] OFF_STAT = 32'h00,
   parameter logic [31:0] OFF_MASK = 32'h04,
   parameter logic [31:0] OFF_ENA  = 32'h08,
   parameter logic [31:0] OFF_DIS  = 32'h0C,
   parameter bit          IRQ_REG  = 1'b0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_wr,
   input  logic               bus_rd,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] hw_event,
   output logic               irq
);
   localparam int LANE_W = $clog2(DATA_W / 8);
   localparam logic [NUM_SRC-1:0] MASK_INIT = MASK_RST[NUM_SRC-1:0];

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8 || DATA_W > 32) begin : g_bad_width
         $error("isr_group: DATA_W must be 8, 16, 24 or 32");
      end
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("isr_group: NUM_SRC must lie in 1..DATA_W");
      end
      if (ADDR_W < LANE_W + 2 || ADDR_W > 32) begin : g_bad_addr
         $error("isr_group: ADDR_W too small for four words");
      end
      if (LANE_W > 0 &&
          ((OFF_STAT | OFF_MASK | OFF_ENA | OFF_DIS) & ((32'd1 << LANE_W) - 32'd1)) != 0)
      begin : g_bad_align
         $error("isr_group: offsets must be word aligned");
      end
      if (OFF_STAT == OFF_MASK || OFF_STAT == OFF_ENA || OFF_STAT == OFF_DIS ||
          OFF_MASK == OFF_ENA  || OFF_MASK == OFF_DIS || OFF_ENA  == OFF_DIS)
      begin : g_bad_map
         $error("isr_group: offsets must be distinct");
      end
   endgenerate

   isr_sel_e           sel;
   logic [NUM_SRC-1:0] wd_src;
   logic [NUM_SRC-1:0] stat_clr;
   logic [NUM_SRC-1:0] mask_clr;
   logic [NUM_SRC-1:0] mask_set;
   logic [NUM_SRC-1:0] stat;
   logic [NUM_SRC-1:0] mask;

   assign wd_src = bus_wdata[NUM_SRC-1:0];

   generate
      if (NUM_SRC < DATA_W) begin : g_unused
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
      end
   endgenerate

   isr_addr_dec #(
      .ADDR_W  (ADDR_W),
      .LANE_W  (LANE_W),
      .OFF_STAT(OFF_STAT),
      .OFF_MASK(OFF_MASK),
      .OFF_ENA (OFF_ENA),
      .OFF_DIS (OFF_DIS)
   ) dec_i (
      .addr(bus_addr),
      .sel (sel)
   );

   assign stat_clr = (bus_wr && sel == SEL_STAT) ? wd_src : '0;
   assign mask_clr = (bus_wr && sel == SEL_ENA)  ? wd_src : '0;
   assign mask_set = (bus_wr && sel == SEL_DIS)  ? wd_src : '0;

   isr_stat_bank #(.NUM_SRC(NUM_SRC)) stat_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (stat_clr),
      .set  (hw_event),
      .stat (stat)
   );

   isr_mask_bank #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_INIT)) mask_i (
      .clk   (clk),
      .rst_n (rst_n),
      .unmask(mask_clr),
      .domask(mask_set),
      .mask  (mask)
   );

   isr_irq_out #(.NUM_SRC(NUM_SRC), .IRQ_REG(IRQ_REG)) irq_i (
      .clk  (clk),
      .rst_n(rst_n),
      .stat (stat),
      .mask (mask),
      .irq  (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            SEL_STAT: bus_rdata[NUM_SRC-1:0] = stat;
            SEL_MASK: bus_rdata[NUM_SRC-1:0] = mask;
            default:  bus_rdata = '0;
         endcase
      end
   end

   // R8: the alias locations read as zero
   assert_alias_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (sel == SEL_ENA || sel == SEL_DIS)) |-> (bus_rdata == '0));

   // R9: misaligned accesses are not decoded
   generate
      if (LANE_W > 0) begin : g_align_chk
         assert_misaligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr[LANE_W-1:0] != '0) |-> (sel == SEL_NONE && bus_rdata == '0));
      end

      if (!IRQ_REG) begin : g_irq_chk
         // R4: masking every source removes the interrupt in the next cycle
         assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && sel == SEL_DIS && (&wd_src)) |=> !irq);
      end
   endgenerate
endmodule

// File: tb/isr_group_tb_top.sv
module isr_group_tb_top;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int N      = 1;
   localparam logic [7:0] A_STAT = 8'h00;
   localparam logic [7:0] A_MASK = 8'h04;
   localparam logic [7:0] A_ENA  = 8'h08;
   localparam logic [7:0] A_DIS  = 8'h0C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [DATA_W-1:0] bus_rdata;
   logic [N-1:0]      hw_event = '0;
   logic              irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [N-1:0] m_stat;
   logic [N-1:0] m_mask;

   always #4 clk = ~clk;

   isr_group dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_rdata(bus_rdata),
      .hw_event (hw_event),
      .irq      (irq)
   );

   function automatic logic exp_irq(logic [N-1:0] s, logic [N-1:0] m);
      return |(s & ~m);
   endfunction

   function automatic logic [DATA_W-1:0] exp_rd(logic [ADDR_W-1:0] a,
                                                logic [N-1:0] s, logic [N-1:0] m);
      logic [DATA_W-1:0] r;
      r = '0;
      if (a == A_STAT) r[N-1:0] = s;
      else if (a == A_MASK) r[N-1:0] = m;
      return r;
   endfunction

   task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic [N-1:0] ev);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      hw_event  = ev;
      if (a == A_STAT) m_stat = m_stat & ~d[N-1:0];
      if (a == A_ENA)  m_mask = m_mask & ~d[N-1:0];
      if (a == A_DIS)  m_mask = m_mask | d[N-1:0];
      m_stat = m_stat | ev;
      @(negedge clk);
      bus_wr   = 1'b0;
      hw_event = '0;
   endtask

   task automatic do_read(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1;
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic chk_regs(string req);
      logic [DATA_W-1:0] d;
      do_read(A_STAT, d);
      chk({req, " status"}, d, exp_rd(A_STAT, m_stat, m_mask));
      do_read(A_MASK, d);
      chk({req, " mask"}, d, exp_rd(A_MASK, m_stat, m_mask));
   endtask

   initial begin
      logic [DATA_W-1:0] d;
      void'($urandom(32'd20240611));
      m_stat = '0;
      m_mask = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk_regs("R1");

      // R10 idle read data is zero
      bus_addr = A_MASK;
      #1;
      chk("R10 idle rdata", bus_rdata, 32'd0);

      // R5 direct mask write ignored
      do_write(A_MASK, 32'h0, '0);
      chk_regs("R5");

      // R3 event sets status, masked so no irq (R4)
      do_write(A_ENA + 8'h20, 32'h0, 1'b1);
      chk("R4 masked irq", {31'd0, irq}, {31'd0, exp_irq(m_stat, m_mask)});
      chk_regs("R3");

      // R6 enable alias unmasks, irq rises
      do_write(A_ENA, 32'hFFFF_FFFF, '0);
      chk("R4 irq after R6", {31'd0, irq}, 32'd1);
      chk_regs("R6");

      // R8 alias reads
      do_read(A_ENA, d);
      chk("R8 enable alias", d, 32'd0);
      do_read(A_DIS, d);
      chk("R8 disable alias", d, 32'd0);

      // R2 writing zero keeps status
      do_write(A_STAT, 32'h0, '0);
      chk_regs("R2 zero write");

      // R3 event beats clear
      do_write(A_STAT, 32'h1, 1'b1);
      chk_regs("R3 priority");
      chk("R3 irq", {31'd0, irq}, 32'd1);

      // R9 misaligned write and read
      do_write(A_STAT + 8'h1, 32'h1, '0);
      do_write(A_DIS + 8'h2, 32'h1, '0);
      chk_regs("R9 write");
      do_read(A_STAT + 8'h3, d);
      chk("R9 read", d, 32'd0);

      // R2 clear
      do_write(A_STAT, 32'h1, '0);
      chk("R4 irq after clear", {31'd0, irq}, 32'd0);
      chk_regs("R2 clear");

      // R7 disable alias
      do_write(A_DIS, 32'h1, '0);
      chk_regs("R7");

      // R10 unmapped read
      do_read(8'h40, d);
      chk("R10 unmapped", d, 32'd0);

      // random mix (R2..R10)
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [ADDR_W-1:0] a;
         logic [DATA_W-1:0] wd;
         logic [N-1:0] ev;
         op = $urandom % 6;
         wd = $urandom;
         ev = (($urandom % 3) == 0) ? '1 : '0;
         case (op)
            0: a = A_STAT;
            1: a = A_MASK;
            2: a = A_ENA;
            3: a = A_DIS;
            4: a = (8'h00 + 8'(4 * ($urandom % 4))) | 8'(1 + $urandom % 3);
            default: a = 8'h80;
         endcase
         do_write(a, wd, ev);
         chk("R4 random irq", {31'd0, irq}, {31'd0, exp_irq(m_stat, m_mask)});
         if ((it % 8) == 0) chk_regs("R10 random");
      end

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule